// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Weight Streaming FIFO

This block moves wide words of packed 4-bit weights from a slower bus clock domain into a faster compute clock domain. Each word is 128 bits wide by default, so it holds 32 weights. The words pass through unchanged. The block smooths out the rate difference between the prefetch engine, which writes one word per write-clock cycle under valid/ready handshaking, and the compute array, which reads under its own valid/ready handshake.

The storage is one dual-clock RAM of `DEPTH` words. It is split into two halves that form a ping-pong pair. The writer fills one half while the reader consumes the other. A half becomes visible to the reader only once all of its words have been written. It goes back to the writer only when the reader is done with it. Only half-pointers cross between the clock domains, as 2-bit Gray codes through two-flop synchronisers.

The reader has two modes:

- **Streaming mode** (`rd_hold` low): a half is handed back on its own as soon as its last word has been taken.
- **Stationary mode** (`rd_hold` high): the reader keeps the tile it is working on. It can replay the tile from the first word with `rd_rewind`, or hand the half back with `rd_release`.

Top module: `weight_pingpong_fifo`

## Requirements
- R1: During and right after reset, `wr_ready` is 1 and `rd_valid` is 0.
- R2: Words come out on `rd_data` in the order they were accepted on the write side, with no loss and no duplication, under any stall pattern on either side.
- R3: Once two full halves are written and neither is handed back, `wr_ready` is 0. No further write is accepted, so at most `DEPTH` words are ever outstanding.
- R4: A half is not offered to the reader until all `DEPTH/2` of its words have been written. With fewer words written, `rd_valid` stays 0.
- R5: `rd_last` is 1 exactly on the final word of each half, which is word index `DEPTH/2-1`.
- R6: In streaming mode, a half returns to the writer once its last word has been taken, without any pulse from the reader.
- R7: In stationary mode, after the last word of a half is taken, `rd_valid` stays 0. A one-cycle `rd_rewind` pulse makes the same half play again from its first word.
- R8: In stationary mode, a one-cycle `rd_release` pulse after the half is fully delivered returns it to the writer. The reader then moves on to the next written half. If both pulses arrive together, release wins.
- R9: `rd_release` and `rd_rewind` have no effect while the current half still has words not yet taken.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side (bus) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be accepted |
| wr_data | input | DW | Packed weight word |
| rd_clk | input | 1 | Read-side (compute) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_hold | input | 1 | 1 = stationary mode, 0 = streaming mode |
| rd_rewind | input | 1 | Replay the held half from its first word |
| rd_release | input | 1 | Return the held half to the writer |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DW | Packed weight word |
| rd_last | output | 1 | Final word of the current half |

## Verification
The bench first writes one word short of a half with the reader idle. A design that exposed partial halves would raise `rd_valid` too early. It then fills both halves with the reader stalled and keeps offering words. A wrong full test would overwrite the unread tile, and the corrupted data would show up later in the order check.

Long runs with random stalls on both sides, against a queue model, catch a lost or doubled word at a half boundary or a missing automatic release. A missing release would show up as a writer that stays blocked. Stationary-mode runs send rewind and release pulses both early and after the last word. A design that acted on early pulses would skip words or repeat words, and one that ignored late pulses would never replay the tile or move on.

// File: rtl/wsf_pkg.sv
package wsf_pkg;

  // Half-pointer: low bit selects the half, high bit is the lap bit.
  typedef logic [1:0] hptr_t;

  function automatic hptr_t to_gray(hptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic hptr_t from_gray(hptr_t g);
    return {g[1], g[1] ^ g[0]};
  endfunction

endpackage

// File: rtl/wsf_sync.sv
module wsf_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/wsf_ram.sv
module wsf_ram #(
  parameter int DW = 128,
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wsf_wr_ctrl.sv
module wsf_wr_ctrl
  import wsf_pkg::*;
#(
  parameter int HAW = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  output logic           ready,
  output logic           we,
  output logic [HAW:0]   waddr,
  input  hptr_t          rd_gray_sync,
  output hptr_t          wr_gray,
  output hptr_t          wr_bin,
  output hptr_t          rd_seen
);

  localparam logic [HAW-1:0] IDX_LAST = {HAW{1'b1}};
  localparam logic [HAW-1:0] IDX_ONE  = {{(HAW-1){1'b0}}, 1'b1};

  logic [HAW-1:0] idx;
  logic           full;
  logic           accept;

  assign rd_seen = from_gray(rd_gray_sync);
  // Both halves owned by the writer's side but not yet returned: same half, other lap.
  assign full    = (wr_bin[0] == rd_seen[0]) && (wr_bin[1] != rd_seen[1]);
  assign ready   = !full;
  assign accept  = valid && ready;
  assign we      = accept;
  assign waddr   = {wr_bin[0], idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (accept) begin
      if (idx == IDX_LAST) begin
        idx     <= '0;
        wr_bin  <= wr_bin + 2'd1;
        wr_gray <= to_gray(wr_bin + 2'd1);
      end else begin
        idx <= idx + IDX_ONE;
      end
    end
  end

endmodule

// File: rtl/wsf_rd_ctrl.sv
module wsf_rd_ctrl
  import wsf_pkg::*;
#(
  parameter int HAW = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         rewind,
  input  logic         release_req,
  input  logic         ready,
  output logic         valid,
  output logic         last,
  output logic         re,
  output logic [HAW:0] raddr,
  input  hptr_t        wr_gray_sync,
  output hptr_t        rd_gray,
  output hptr_t        rd_bin
);

  localparam logic [HAW:0]   IDX_END  = {1'b1, {HAW{1'b0}}};
  localparam logic [HAW:0]   IDX_ONE  = {{HAW{1'b0}}, 1'b1};
  localparam logic [HAW-1:0] IDX_LAST = {HAW{1'b1}};

  logic [HAW:0] idx;
  hptr_t        wr_seen;
  logic         avail;
  logic         drained;
  logic         issue;
  logic         do_release;
  logic         do_rewind;

  assign wr_seen    = from_gray(wr_gray_sync);
  assign avail      = (rd_bin != wr_seen);
  assign drained    = (idx == IDX_END) && !valid;
  assign issue      = avail && (idx != IDX_END) && (!valid || ready);
  assign do_release = drained && (!hold || release_req);
  assign do_rewind  = drained && hold && rewind && !release_req;
  assign re         = issue;
  assign raddr      = {rd_bin[0], idx[HAW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      last  <= 1'b0;
    end else if (issue) begin
      valid <= 1'b1;
      last  <= (idx[HAW-1:0] == IDX_LAST);
    end else if (ready) begin
      valid <= 1'b0;
      last  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (issue) begin
      idx <= idx + IDX_ONE;
    end else if (do_release) begin
      idx     <= '0;
      rd_bin  <= rd_bin + 2'd1;
      rd_gray <= to_gray(rd_bin + 2'd1);
    end else if (do_rewind) begin
      idx <= '0;
    end
  end

endmodule

// File: rtl/weight_pingpong_fifo.sv
module weight_pingpong_fifo
  import wsf_pkg::*;
#(
  parameter int DW    = 128,
  parameter int DEPTH = 4096
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_hold,
  input  logic          rd_rewind,
  input  logic          rd_release,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);

  localparam int HALF = DEPTH / 2;
  localparam int HAW  = $clog2(HALF);
  localparam int AW   = HAW + 1;

  logic          ram_we;
  logic          ram_re;
  logic [AW-1:0] ram_waddr;
  logic [AW-1:0] ram_raddr;
  hptr_t         wr_gray;
  hptr_t         rd_gray;
  hptr_t         wr_gray_at_rd;
  hptr_t         rd_gray_at_wr;
  hptr_t         wr_hptr_bin;
  hptr_t         rd_hptr_bin;
  hptr_t         rd_hptr_at_wr;

  wsf_wr_ctrl #(.HAW(HAW)) u_wr_ctrl (
    .clk          (wr_clk),
    .rst          (wr_rst),
    .valid        (wr_valid),
    .ready        (wr_ready),
    .we           (ram_we),
    .waddr        (ram_waddr),
    .rd_gray_sync (rd_gray_at_wr),
    .wr_gray      (wr_gray),
    .wr_bin       (wr_hptr_bin),
    .rd_seen      (rd_hptr_at_wr)
  );

  wsf_sync #(.W(2)) u_sync_wr2rd (
    .clk (rd_clk),
    .rst (rd_rst),
    .d   (wr_gray),
    .q   (wr_gray_at_rd)
  );

  wsf_sync #(.W(2)) u_sync_rd2wr (
    .clk (wr_clk),
    .rst (wr_rst),
    .d   (rd_gray),
    .q   (rd_gray_at_wr)
  );

  wsf_rd_ctrl #(.HAW(HAW)) u_rd_ctrl (
    .clk          (rd_clk),
    .rst          (rd_rst),
    .hold         (rd_hold),
    .rewind       (rd_rewind),
    .release_req  (rd_release),
    .ready        (rd_ready),
    .valid        (rd_valid),
    .last         (rd_last),
    .re           (ram_re),
    .raddr        (ram_raddr),
    .wr_gray_sync (wr_gray_at_rd),
    .rd_gray      (rd_gray),
    .rd_bin       (rd_hptr_bin)
  );

  wsf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/wsf_checker.sv
module wsf_checker #(
  parameter int DW = 128
) (
  input logic          wr_clk,
  input logic          wr_rst,
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_hold,
  input logic          rd_rewind,
  input logic          rd_release,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_last,
  input logic [1:0]    wr_hptr,
  input logic [1:0]    rd_hptr_seen,
  input logic [1:0]    rd_hptr
);

  assert_reset_idle_R1: assert property (@(posedge rd_clk)
    rd_rst |=> !rd_valid);

  // R3: the writer never runs more than two halves ahead of what it has seen returned
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (2'(wr_hptr - rd_hptr_seen)) != 2'd3);

  assert_last_with_valid_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_last |-> rd_valid);

  assert_hold_stops_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_hold && rd_valid && rd_ready && rd_last |=> !rd_valid);

  assert_early_pulse_ignored_R9: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_release || rd_rewind) && rd_valid |=> $stable(rd_hptr));

  assert_stall_holds_data_R10: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

endmodule

bind weight_pingpong_fifo wsf_checker #(.DW(DW)) u_wsf_checker (
  .wr_clk       (wr_clk),
  .wr_rst       (wr_rst),
  .rd_clk       (rd_clk),
  .rd_rst       (rd_rst),
  .rd_hold      (rd_hold),
  .rd_rewind    (rd_rewind),
  .rd_release   (rd_release),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_data      (rd_data),
  .rd_last      (rd_last),
  .wr_hptr      (wr_hptr_bin),
  .rd_hptr_seen (rd_hptr_at_wr),
  .rd_hptr      (rd_hptr_bin)
);

// File: tb/test_weight_pingpong_fifo.sv
`timescale 1ns/1ps
module test_weight_pingpong_fifo;

  localparam int DW    = 128;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst = 1'b1;
  logic          rd_rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          rd_hold = 1'b0;
  logic          rd_rewind = 1'b0;
  logic          rd_release = 1'b0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_last;

  always #2.0  wr_clk = ~wr_clk;   // 250 MHz
  always #1.25 rd_clk = ~rd_clk;   // 400 MHz

  weight_pingpong_fifo #(.DW(DW), .DEPTH(DEPTH)) i_weight_pingpong_fifo (
    .wr_clk     (wr_clk),
    .wr_rst     (wr_rst),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .rd_clk     (rd_clk),
    .rd_rst     (rd_rst),
    .rd_hold    (rd_hold),
    .rd_rewind  (rd_rewind),
    .rd_release (rd_release),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .rd_last    (rd_last)
  );

  // Reference model: every accepted word in order, plus the reader's position.
  logic [DW-1:0] stream [$];
  int hnum = 0;
  int kpos = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] rword();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [DW-1:0] expected_word();
    int pos = hnum * HALF + kpos;
    if (pos < stream.size()) return stream[pos];
    return '0;
  endfunction

  task automatic write_words(int n, int stall);
    int got = 0;
    logic [DW-1:0] w = rword();
    while (got < n) begin
      @(negedge wr_clk);
      wr_valid = ($urandom_range(99) >= stall);
      wr_data  = w;
      if (wr_valid && wr_ready) begin
        stream.push_back(w);
        got++;
        w = rword();
      end
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_words(int n, int stall);
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      rd_ready = ($urandom_range(99) >= stall);
      if (rd_valid && rd_ready) begin
        logic [DW-1:0] exp = expected_word();
        check(rd_data === exp, "R2 word order", rd_data, exp);
        check(rd_last === (kpos == HALF - 1), "R5 last flag", DW'(rd_last), DW'(kpos == HALF - 1));
        got++;
        kpos++;
        if (kpos == HALF && !rd_hold) begin
          hnum++;
          kpos = 0;
        end
      end
    end
    @(negedge rd_clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse(bit is_release, bit effective);
    @(negedge rd_clk);
    if (is_release) rd_release = 1'b1;
    else            rd_rewind  = 1'b1;
    @(negedge rd_clk);
    rd_release = 1'b0;
    rd_rewind  = 1'b0;
    if (effective) begin
      if (is_release) hnum++;
      kpos = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=completed");
    finish_run();
  end

  initial begin
    logic [DW-1:0] first;
    int acc;

    repeat (10) @(negedge wr_clk);
    check(wr_ready === 1'b1, "R1 wr_ready in reset", DW'(wr_ready), DW'(1));
    check(rd_valid === 1'b0, "R1 rd_valid in reset", DW'(rd_valid), DW'(0));
    @(negedge wr_clk);
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    repeat (3) @(negedge wr_clk);
    check(wr_ready === 1'b1, "R1 wr_ready after reset", DW'(wr_ready), DW'(1));
    check(rd_valid === 1'b0, "R1 rd_valid after reset", DW'(rd_valid), DW'(0));

    // R4: a partly written half stays hidden
    write_words(HALF - 1, 0);
    repeat (30) @(negedge rd_clk);
    check(rd_valid === 1'b0, "R4 partial half hidden", DW'(rd_valid), DW'(0));
    write_words(1, 0);
    repeat (10) @(negedge rd_clk);
    check(rd_valid === 1'b1, "R4 full half visible", DW'(rd_valid), DW'(1));
    check(rd_data === stream[0], "R4 first word", rd_data, stream[0]);
    first = rd_data;
    repeat (5) @(negedge rd_clk);
    check(rd_valid === 1'b1 && rd_data === first, "R10 stalled word held", rd_data, first);

    // R3: both halves written, reader stalled
    write_words(HALF, 0);
    repeat (10) @(negedge wr_clk);
    check(wr_ready === 1'b0, "R3 full after two halves", DW'(wr_ready), DW'(0));
    acc = 0;
    repeat (20) begin
      @(negedge wr_clk);
      wr_valid = 1'b1;
      wr_data  = rword();
      if (wr_ready) acc++;
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
    check(acc == 0, "R3 writes refused when full", DW'(acc), DW'(0));

    // R2/R5/R6: streaming with random stalls on both sides
    fork
      write_words(4 * HALF, 30);
      read_words(6 * HALF, 30);
    join
    repeat (20) @(negedge rd_clk);
    check(rd_valid === 1'b0, "R6 drained", DW'(rd_valid), DW'(0));
    check(wr_ready === 1'b1, "R6 halves returned automatically", DW'(wr_ready), DW'(1));

    // R7/R8/R9: stationary mode
    @(negedge rd_clk);
    rd_hold = 1'b1;
    fork
      write_words(2 * HALF, 20);
      read_words(HALF, 20);
    join
    repeat (10) @(negedge rd_clk);
    check(rd_valid === 1'b0, "R7 held tile stops", DW'(rd_valid), DW'(0));
    check(wr_ready === 1'b0, "R3 held half blocks writer", DW'(wr_ready), DW'(0));
    pulse(1'b0, 1'b1);                      // rewind, replay from first word (R7)
    read_words(HALF / 2, 20);
    pulse(1'b1, 1'b0);                      // early release, ignored (R9)
    pulse(1'b0, 1'b0);                      // early rewind, ignored (R9)
    repeat (4) @(negedge rd_clk);
    check(rd_valid === 1'b1 && rd_data === expected_word(), "R9 early pulses ignored",
          rd_data, expected_word());
    read_words(HALF - HALF / 2, 20);
    pulse(1'b1, 1'b1);                      // release (R8)
    repeat (10) @(negedge wr_clk);
    check(wr_ready === 1'b1, "R8 release frees half", DW'(wr_ready), DW'(1));
    read_words(HALF, 20);                   // next half, R8
    pulse(1'b1, 1'b1);

    @(negedge rd_clk);
    rd_hold = 1'b0;
    fork
      write_words(HALF, 0);
      read_words(HALF, 0);
    join
    repeat (10) @(negedge rd_clk);
    check(rd_valid === 1'b0, "R6 final drain", DW'(rd_valid), DW'(0));

    finish_run();
  end

endmodule